// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master for serial flash devices. A 32-bit register port holds two control words, a status word, a transmit word and a receive word. Software can run raw transfers: up to four command bytes taken from the transmit word, then up to four reply bytes collected into the receive word. Two trigger bits send the two most common fixed commands without using the transmit word. One reads the flash status byte into the status word. The other is the single-byte write-enable command.

The bus runs in SPI mode 3. The clock idles high, data leaves on the falling edge, and MISO is sampled on the rising edge. Each half period lasts `CLK_HALF` system clocks. One of four chip selects, picked by a bank field, stays low from the first falling edge until the last rising edge. A sticky done flag reports completion. A busy flag reports a transfer in flight. Two mode bits are kept for the memory-window logic elsewhere and have no effect here. The register port has no back-pressure. A write takes effect at the clock edge where `reg_sel && reg_wr` is high. A read returns the addressed word combinationally and changes nothing.

Top module: `spimc_top`

## Requirements
- R1: After reset every register reads zero, all chip selects are high (inactive), SCK is high and MOSI is low.
- R2: In a transfer, SCK falls in the cycle after the starting write and then toggles every `CLK_HALF` cycles. MOSI changes only while SCK is low, and MISO is sampled when SCK rises.
- R3: Registers sit at word offsets 0x00 (control A), 0x04 (control B), 0x08 (status), 0x0C (transmit) and 0x10 (receive). Control A stores bits 28 and 29 and reads all of its other bits as zero.
- R4: Control B bit 7 starts a raw transfer. It sends the number of bytes given in bits [2:0], taken from the transmit word starting with bits [7:0] and moving upward. Each byte goes out most significant bit first.
- R5: Control B bits [6:4] give the number of reply bytes, and MOSI is low while they are clocked in. The first reply byte lands in receive bits [7:0], and receive bytes beyond the count read zero. A byte count above 4 is treated as 4.
- R6: Control B bits [13:12] select which one of the four chip selects goes low. It goes low for the whole transfer and returns high right after the last rising edge.
- R7: Control B bit 10 sends opcode 0x05, clocks in one byte and places it in status bits [7:0]. The receive word is left unchanged.
- R8: Control B bit 11 sends opcode 0x06 as a one-byte transfer with no reply. When several trigger bits are written together, bit 10 wins over bit 11, and bit 11 wins over bit 7.
- R9: Status bit 8 sets when a transfer ends. Writing 0 to it clears it and writing 1 leaves it unchanged. A completion in the same cycle as a clear leaves it set.
- R10: Status bit 9 is high while a transfer runs. A control B write during a transfer is ignored completely.
- R11: A bit 7 request whose transmit and receive counts are both zero starts nothing and leaves status bit 8 clear.
- R12: Trigger bits 7, 10 and 11 read back as zero. The count and bank fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational, zero when not selected) |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 4 | Active-low chip selects, one per bank |

## Verification
Call the edge that captures a starting write E0. SCK is low from E0. It rises at E0 + `CLK_HALF`, and one bit takes 2·`CLK_HALF` cycles. The chip select, the done flag, the busy flag and the receive or status result all settle together at E0 + 2·`CLK_HALF`·bits. The reference model in the bench arms a timer at the write. At every clock, a quarter period after the edge, it compares SCK and the chip selects against the closed-form waveform. Register results are read only after the model's timer has run out, and the busy flag is sampled while it is still running.

// File: rtl/spimc_pkg.sv
package spimc_pkg;
  localparam int DW        = 32;
  localparam int AW        = 5;
  localparam int MAX_BYTES = 4;

  localparam logic [AW-1:0] OFS_CTLA = 5'h00;
  localparam logic [AW-1:0] OFS_CTLB = 5'h04;
  localparam logic [AW-1:0] OFS_STAT = 5'h08;
  localparam logic [AW-1:0] OFS_TXW  = 5'h0C;
  localparam logic [AW-1:0] OFS_RXW  = 5'h10;

  localparam int A_SWMODE = 28;
  localparam int A_BURST  = 29;
  localparam int B_NTX    = 0;
  localparam int B_NRX    = 4;
  localparam int B_GO     = 7;
  localparam int B_RDST   = 10;
  localparam int B_WREN   = 11;
  localparam int B_BANK   = 12;
  localparam int S_DONE   = 8;
  localparam int S_BUSY   = 9;

  localparam logic [7:0] OPC_RDST = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;

  typedef struct packed {
    logic [1:0]    bank;
    logic [2:0]    ntx;
    logic [2:0]    nrx;
    logic [DW-1:0] txw;
  } job_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH} eng_st_e;

  function automatic logic [2:0] clamp_len(input logic [2:0] v);
    return (v > 3'd4) ? 3'd4 : v;
  endfunction
endpackage

// File: rtl/spimc_clkdiv.sv
module spimc_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spimc_engine.sv
module spimc_engine
  import spimc_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  job_t          job,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sck,
  output logic          mosi,
  output logic [NCS-1:0] cs_n
);
  localparam int BIT_W = $clog2(16 * MAX_BYTES + 1);

  eng_st_e        st;
  logic [BIT_W-1:0] bitcnt, total, txbits;
  logic [DW-1:0]  txsh, rxsh;
  logic [2:0]     nrx_q;
  logic           tick;
  logic [DW-1:0]  arranged;
  logic [BIT_W-1:0] nxt_bit;

  assign busy = (st != ENG_IDLE);

  spimc_clkdiv #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  // byte 0 of the transmit word leaves first, each byte MSB first
  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++)
      arranged[DW-1-8*i -: 8] = job.txw[8*i +: 8];
  end

  assign nxt_bit = bitcnt + 1'b1;

  // first reply byte lands in the lowest byte of the result
  always_comb begin
    rx_word = '0;
    for (int i = 0; i < MAX_BYTES; i++)
      if (i < int'(nrx_q))
        rx_word[8*i +: 8] = rxsh[8*(int'(nrx_q) - 1 - i) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      bitcnt <= '0;
      total  <= '0;
      txbits <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      nrx_q  <= '0;
      sck    <= 1'b1;
      mosi   <= 1'b0;
      cs_n   <= '1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ENG_IDLE: if (start) begin
          st     <= ENG_LOW;
          bitcnt <= '0;
          txbits <= BIT_W'({job.ntx, 3'b000});
          total  <= BIT_W'({1'b0, job.ntx} + {1'b0, job.nrx}) << 3;
          nrx_q  <= job.nrx;
          txsh   <= arranged;
          rxsh   <= '0;
          sck    <= 1'b0;
          mosi   <= (job.ntx != 3'd0) ? arranged[DW-1] : 1'b0;
          cs_n   <= ~(NCS'(1) << job.bank);
        end
        ENG_LOW: if (tick) begin
          st  <= ENG_HIGH;
          sck <= 1'b1;
          if (bitcnt >= txbits) rxsh <= {rxsh[DW-2:0], miso};
        end
        ENG_HIGH: if (tick) begin
          if (nxt_bit == total) begin
            st   <= ENG_IDLE;
            cs_n <= '1;
            done <= 1'b1;
          end else begin
            st     <= ENG_LOW;
            sck    <= 1'b0;
            bitcnt <= nxt_bit;
            txsh   <= txsh << 1;
            mosi   <= (nxt_bit < txbits) ? txsh[DW-2] : 1'b0;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> sck);
  // R2
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck);
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cs_n) || (&cs_n));
endmodule

// File: rtl/spimc_regs.sv
module spimc_regs
  import spimc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  output logic          start,
  output job_t          job
);
  logic          swm, wbm;
  logic [2:0]    c_ntx, c_nrx;
  logic [1:0]    c_bank;
  logic [DW-1:0] txd, rxd;
  logic [7:0]    fstat;
  logic          tff;
  logic          pend_stat, pend_rx;
  logic          wr_b, wr_a, wr_s, wr_t;
  logic          req_rd, req_we, req_go;
  logic [2:0]    go_ntx, go_nrx;

  assign wr_a = reg_sel && reg_wr && (reg_addr == OFS_CTLA);
  assign wr_b = reg_sel && reg_wr && (reg_addr == OFS_CTLB) && !busy;
  assign wr_s = reg_sel && reg_wr && (reg_addr == OFS_STAT);
  assign wr_t = reg_sel && reg_wr && (reg_addr == OFS_TXW);

  assign req_rd = reg_wdata[B_RDST];
  assign req_we = reg_wdata[B_WREN];
  assign req_go = reg_wdata[B_GO];
  assign go_ntx = clamp_len(reg_wdata[B_NTX +: 3]);
  assign go_nrx = clamp_len(reg_wdata[B_NRX +: 3]);

  always_comb begin
    job.bank = reg_wdata[B_BANK +: 2];
    job.ntx  = go_ntx;
    job.nrx  = go_nrx;
    job.txw  = txd;
    start    = 1'b0;
    if (wr_b) begin
      if (req_rd) begin
        job.ntx = 3'd1; job.nrx = 3'd1; job.txw = DW'(OPC_RDST); start = 1'b1;
      end else if (req_we) begin
        job.ntx = 3'd1; job.nrx = 3'd0; job.txw = DW'(OPC_WREN); start = 1'b1;
      end else if (req_go) begin
        start = (go_ntx != 3'd0) || (go_nrx != 3'd0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swm <= 1'b0; wbm <= 1'b0;
      c_ntx <= '0; c_nrx <= '0; c_bank <= '0;
      txd <= '0; rxd <= '0; fstat <= '0; tff <= 1'b0;
      pend_stat <= 1'b0; pend_rx <= 1'b0;
    end else begin
      if (wr_a) begin
        swm <= reg_wdata[A_SWMODE];
        wbm <= reg_wdata[A_BURST];
      end
      if (wr_t) txd <= reg_wdata;
      if (wr_b) begin
        c_ntx  <= reg_wdata[B_NTX +: 3];
        c_nrx  <= reg_wdata[B_NRX +: 3];
        c_bank <= reg_wdata[B_BANK +: 2];
      end
      if (start) begin
        pend_stat <= req_rd;
        pend_rx   <= !req_rd && !req_we && (go_nrx != 3'd0);
      end
      if (wr_s && !reg_wdata[S_DONE]) tff <= 1'b0;
      if (done) begin
        tff <= 1'b1;
        if (pend_stat) fstat <= rx_word[7:0];
        if (pend_rx)   rxd   <= rx_word;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr) begin
      unique case (reg_addr)
        OFS_CTLA: begin
          reg_rdata[A_SWMODE] = swm;
          reg_rdata[A_BURST]  = wbm;
        end
        OFS_CTLB: begin
          reg_rdata[B_NTX +: 3]  = c_ntx;
          reg_rdata[B_NRX +: 3]  = c_nrx;
          reg_rdata[B_BANK +: 2] = c_bank;
        end
        OFS_STAT: begin
          reg_rdata[7:0]    = fstat;
          reg_rdata[S_DONE] = tff;
          reg_rdata[S_BUSY] = busy;
        end
        OFS_TXW: reg_rdata = txd;
        OFS_RXW: reg_rdata = rxd;
        default: reg_rdata = '0;
      endcase
    end
  end

  // R9
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tff);
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_addr == OFS_CTLB && busy)
      |=> $stable({c_ntx, c_nrx, c_bank}));
  // R7
  rx_kept_on_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pend_stat) |=> $stable(rxd));
endmodule

// File: rtl/spimc_top.sv
module spimc_top
  import spimc_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int NBANK    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [NBANK-1:0] spi_cs_n
);
  logic          busy, done, start;
  logic [DW-1:0] rx_word;
  job_t          job;

  spimc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .done     (done),
    .rx_word  (rx_word),
    .start    (start),
    .job      (job)
  );

  spimc_engine #(.NCS(NBANK), .HALF(CLK_HALF)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .job    (job),
    .miso   (spi_miso),
    .busy   (busy),
    .done   (done),
    .rx_word(rx_word),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .cs_n   (spi_cs_n)
  );
endmodule

// File: tb/test_spimc_top.sv
module test_spimc_top;
  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  spimc_top #(.CLK_HALF(D), .NBANK(4)) i_spimc_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model: samples MOSI on rising SCK, drives MISO on falling SCK
  logic [7:0] fl_reply [8];
  int         fl_cnt = 0;
  logic       fl_bits [$];
  initial spi_miso = 1'b0;
  always @(negedge spi_sck)
    if (!(&spi_cs_n)) spi_miso = fl_reply[(fl_cnt / 8) % 8][7 - (fl_cnt % 8)];
  always @(posedge spi_sck)
    if (!(&spi_cs_n)) begin fl_bits.push_back(spi_mosi); fl_cnt++; end

  // waveform model
  int   m_arm = 0, m_t = 0, m_total = 0, m_bank = 0;
  bit   m_active = 0;
  int   m_arm_bank = 0;
  logic exp_sck;
  logic [3:0] exp_cs;
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (m_arm != 0) begin
        m_active = 1; m_t = 0; m_total = m_arm * 2 * D; m_bank = m_arm_bank; m_arm = 0;
      end
      exp_sck = m_active ? ((m_t % (2 * D)) >= D) : 1'b1;
      exp_cs  = m_active ? ~(4'b1 << m_bank) : 4'hF;
      chk("R2 sck", {31'b0, spi_sck}, {31'b0, exp_sck});
      chk("R6 cs", {28'b0, spi_cs_n}, {28'b0, exp_cs});
      if (m_active) begin
        m_t++;
        if (m_t == m_total) m_active = 0;
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input int bits, input int bank);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (bits != 0) begin
      fl_cnt = 0; fl_bits.delete(); m_arm_bank = bank; m_arm = bits;
    end
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic wait_idle();
    while (m_active || m_arm != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_sent(input string req, input int n, input logic [31:0] exp);
    logic [31:0] got = '0;
    chk({req, " bitcount"}, fl_bits.size(), n * 8);
    for (int b = 0; b < n && b < 4; b++)
      for (int k = 0; k < 8; k++)
        if (b * 8 + k < fl_bits.size()) got[8 * b + 7 - k] = fl_bits[b * 8 + k];
    chk(req, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) fl_reply[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h00, v); chk("R1 ctla", v, 0);
    rd(5'h04, v); chk("R1 ctlb", v, 0);
    rd(5'h08, v); chk("R1 stat", v, 0);
    rd(5'h0C, v); chk("R1 txw", v, 0);
    rd(5'h10, v); chk("R1 rxw", v, 0);
    chk("R1 mosi", {31'b0, spi_mosi}, 0);
    // R3 control A
    wr(5'h00, 32'hFFFF_FFFF, 0, 0);
    rd(5'h00, v); chk("R3 ctla", v, 32'h3000_0000);
    // R4 erase-style word on bank 2
    wr(5'h0C, 32'h5634_12D8, 0, 0);
    rd(5'h0C, v); chk("R3 txw", v, 32'h5634_12D8);
    wr(5'h04, 32'h0000_2084, 32, 2);
    wait_idle();
    chk_sent("R4 bytes", 4, 32'h5634_12D8);
    rd(5'h08, v); chk("R9 flag set", v, 32'h0000_0100);
    // R9 clearing
    wr(5'h08, 32'h0000_0100, 0, 0);
    rd(5'h08, v); chk("R9 write1 keeps", v, 32'h0000_0100);
    wr(5'h08, 32'h0, 0, 0);
    rd(5'h08, v); chk("R9 write0 clears", v, 0);
    // R5 id style: 1 tx, 3 rx, bank 0
    fl_reply[1] = 8'hC2; fl_reply[2] = 8'h20; fl_reply[3] = 8'h17;
    wr(5'h0C, 32'h0000_009F, 0, 0);
    wr(5'h04, 32'h0000_00B1, 32, 0);
    wait_idle();
    chk_sent("R5 sent with low mosi", 4, 32'h0000_009F);
    rd(5'h10, v); chk("R5 rx", v, 32'h0017_20C2);
    rd(5'h04, v); chk("R12 ctlb readback", v, 32'h0000_0031);
    // R7 status read on bank 1
    fl_reply[1] = 8'h03;
    wr(5'h04, 32'h0000_1400, 16, 1);
    wait_idle();
    chk_sent("R7 opcode", 2, 32'h0000_0005);
    rd(5'h08, v); chk("R7 stat byte", v, 32'h0000_0103);
    rd(5'h10, v); chk("R7 rx kept", v, 32'h0017_20C2);
    // R8 write enable beats go, bank 3
    wr(5'h08, 32'h0, 0, 0);
    wr(5'h04, 32'h0000_3884, 8, 3);
    wait_idle();
    chk_sent("R8 wren", 1, 32'h0000_0006);
    rd(5'h04, v); chk("R12 triggers zero", v, 32'h0000_3004);
    rd(5'h10, v); chk("R8 rx kept", v, 32'h0017_20C2);
    // R8 status read beats write enable
    fl_reply[1] = 8'h82;
    wr(5'h04, 32'h0000_0C80, 16, 0);
    wait_idle();
    chk_sent("R8 priority", 2, 32'h0000_0005);
    rd(5'h08, v); chk("R8 stat byte", v, 32'h0000_0182);
    // R5 clamp: rx count 7 acts as 4
    fl_reply[1] = 8'h11; fl_reply[2] = 8'h22; fl_reply[3] = 8'h33;
    fl_reply[4] = 8'h44; fl_reply[5] = 8'h55;
    wr(5'h0C, 32'h0000_00A5, 0, 0);
    wr(5'h04, 32'h0000_00F1, 40, 0);
    wait_idle();
    rd(5'h10, v); chk("R5 clamp", v, 32'h4433_2211);
    // R10 busy and ignored write
    wr(5'h08, 32'h0, 0, 0);
    wr(5'h04, 32'h0000_0084, 32, 0);
    repeat (10) @(negedge clk);
    rd(5'h08, v); chk("R10 busy bit", v & 32'h300, 32'h200);
    wr(5'h04, 32'h0000_3081, 0, 0);
    wait_idle();
    rd(5'h04, v); chk("R10 ignored write", v, 32'h0000_0004);
    rd(5'h08, v); chk("R10 idle", v & 32'h300, 32'h100);
    chk_sent("R10 single transfer", 4, 32'h0000_00A5);
    // R11 zero-length request
    wr(5'h08, 32'h0, 0, 0);
    wr(5'h04, 32'h0000_0080, 0, 0);
    repeat (40) @(negedge clk);
    rd(5'h08, v); chk("R11 no flag", v & 32'h300, 0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule